// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a core's load/store pipe and a data memory organised as 32-bit words. For a store it turns a byte address and an access size into a word address, a four-bit lane enable and a write word in which the store data already sits on the right lanes. For a load it takes the word the memory returns, picks out the addressed byte, halfword or word, and widens it to 32 bits. Signed loads copy the sign bit and unsigned loads fill with zeros.

The lane numbering is fixed at elaboration by a parameter. With little-endian numbering the lowest address holds the least significant byte. With big-endian numbering it holds the most significant byte. The block is purely combinational. Both the lane enables and the load result follow their inputs in the same cycle. An access whose address does not suit its size, or that uses the reserved size code, raises a fault flag instead of touching memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr` always equals `acc_addr` with its two least-significant bits forced to zero.
- R2: A byte access (size code 00) enables exactly one lane. That lane is `acc_addr[1:0]` with little-endian numbering and `3 - acc_addr[1:0]` with big-endian numbering. Lane i covers word bits 8*i+7..8*i.
- R3: A halfword access (size code 01) with `acc_addr[0]` = 0 enables lanes 1..0 or lanes 3..2. The upper pair is chosen when `acc_addr[1]` = 1 with little-endian numbering, and when `acc_addr[1]` = 0 with big-endian numbering.
- R4: A word access (size code 10) at an address with bits 1..0 = 00 enables all four lanes and drives `wr_data` unchanged onto `mem_wdata`.
- R5: `misalign` is 1 and `mem_be` is 0000 in three cases: a halfword with `acc_addr[0]` = 1, a word with `acc_addr[1:0]` not 00, or size code 11. Otherwise `misalign` is 0.
- R6: For a byte store, `mem_wdata` is `wr_data[7:0]` repeated on all four lanes. For a halfword store it is `wr_data[15:0]` repeated twice. Written through the enables, the addressed bytes of memory take the store data in the configured byte order, and the other bytes keep their values.
- R7: A byte load returns the byte at the addressed location of `mem_rdata`. It is sign-extended when `acc_unsigned` = 0 and zero-extended when `acc_unsigned` = 1, so 0xFE loads as 0xFFFFFFFE or 0x000000FE.
- R8: A halfword load returns the two addressed bytes, with the lower address as the high byte for big-endian numbering and as the low byte for little-endian numbering. It is extended as in R7.
- R9: A word load returns `mem_rdata` unchanged whatever the value of `acc_unsigned`.
- R10: While `misalign` is 1, `rd_value` is 0.
- R11: For the word 0x87654321, addresses 0..3 hold 0x87, 0x65, 0x43, 0x21 with big-endian numbering and 0x21, 0x43, 0x65, 0x87 with little-endian numbering. This holds for both word stores and byte loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| acc_unsigned | input | 1 | 1 selects zero extension on loads |
| wr_data | input | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Word returned by memory |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Lane enables, bit i for bits 8*i+7..8*i |
| mem_wdata | output | 32 | Store data placed on the lanes |
| rd_value | output | 32 | Extracted and extended load value |
| misalign | output | 1 | Access does not suit its size |

## Verification
The bench builds two copies side by side. One uses little-endian numbering with a 32-bit address. The other uses big-endian numbering with a 16-bit address. Every stimulus is applied to both, so every lane mapping is compared across the two byte orders, and the narrow address checks that the word-address path follows `ADDR_W`. Expected values come from a byte-by-address memory model, not from lane arithmetic. This model catches a swapped lane or a wrong byte order within a halfword in either configuration.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam int unsigned LANE_W     = 8;
   localparam int unsigned WORD_LANES = 4;
   localparam int unsigned WORD_W     = LANE_W * WORD_LANES;
   localparam int unsigned OFFS_W     = $clog2(WORD_LANES);

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
   import lsu_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [OFFS_W-1:0]     offset,
   input  acc_size_e             size,
   output logic [WORD_LANES-1:0] lane_be,
   output logic [OFFS_W-1:0]     byte_lane,
   output logic                  half_upper,
   output logic                  fault
);

   generate
      if (BIG_ENDIAN) begin : g_big
         assign byte_lane  = ~offset;
         assign half_upper = ~offset[1];
      end else begin : g_little
         assign byte_lane  = offset;
         assign half_upper = offset[1];
      end
   endgenerate

   always_comb begin
      lane_be = '0;
      fault   = 1'b0;
      unique case (size)
         SZ_BYTE: lane_be = WORD_LANES'(1) << byte_lane;
         SZ_HALF: begin
            if (offset[0]) fault = 1'b1;
            else           lane_be = half_upper ? 4'b1100 : 4'b0011;
         end
         SZ_WORD: begin
            if (offset != '0) fault = 1'b1;
            else              lane_be = '1;
         end
         default: fault = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
   import lsu_pkg::*;
(
   input  acc_size_e         size,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] lane_data
);

   for (genvar i = 0; i < WORD_LANES; i++) begin : g_lane
      logic [LANE_W-1:0] pick;
      always_comb begin
         unique case (size)
            SZ_BYTE: pick = wr_data[LANE_W-1:0];
            SZ_HALF: pick = wr_data[LANE_W*(i%2) +: LANE_W];
            default: pick = wr_data[LANE_W*i +: LANE_W];
         endcase
      end
      assign lane_data[LANE_W*i +: LANE_W] = pick;
   end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_pkg::*;
(
   input  logic [WORD_W-1:0] rdata,
   input  acc_size_e         size,
   input  logic              zero_ext,
   input  logic [OFFS_W-1:0] byte_lane,
   input  logic              half_upper,
   input  logic              fault,
   output logic [WORD_W-1:0] value
);

   localparam int unsigned HALF_W = 2 * LANE_W;

   logic [LANE_W-1:0] sel_byte;
   logic [HALF_W-1:0] sel_half;
   logic              fill;

   assign sel_byte = rdata[LANE_W*byte_lane +: LANE_W];
   assign sel_half = half_upper ? rdata[WORD_W-1 -: HALF_W] : rdata[HALF_W-1:0];

   always_comb begin
      fill  = 1'b0;
      value = '0;
      if (!fault) begin
         unique case (size)
            SZ_BYTE: begin
               fill  = ~zero_ext & sel_byte[LANE_W-1];
               value = {{(WORD_W-LANE_W){fill}}, sel_byte};
            end
            SZ_HALF: begin
               fill  = ~zero_ext & sel_half[HALF_W-1];
               value = {{(WORD_W-HALF_W){fill}}, sel_half};
            end
            SZ_WORD: value = rdata;
            default: value = '0;
         endcase
      end
   end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
   import lsu_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b0
) (
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic              acc_unsigned,
   input  logic [31:0]       wr_data,
   input  logic [31:0]       mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   output logic [31:0]       rd_value,
   output logic              misalign
);

   generate
      if (ADDR_W <= OFFS_W) begin : g_bad_addr_w
         $error("lsu_lane_unit: ADDR_W must exceed the lane offset width");
      end
      if (WORD_W != 32) begin : g_bad_word_w
         $error("lsu_lane_unit: the data path is built for 32-bit words");
      end
   endgenerate

   acc_size_e             size;
   logic [OFFS_W-1:0]     offs;
   logic [WORD_LANES-1:0] lane_be;
   logic [OFFS_W-1:0]     byte_lane;
   logic                  half_upper;
   logic                  fault;

   assign size     = acc_size_e'(acc_size);
   assign offs     = acc_addr[OFFS_W-1:0];
   assign mem_addr = {acc_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
   assign mem_be   = lane_be;
   assign misalign = fault;

   lsu_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) u_map (
      .offset     (offs),
      .size       (size),
      .lane_be    (lane_be),
      .byte_lane  (byte_lane),
      .half_upper (half_upper),
      .fault      (fault)
   );

   lsu_store_align u_store (
      .size      (size),
      .wr_data   (wr_data),
      .lane_data (mem_wdata)
   );

   lsu_load_extract u_load (
      .rdata      (mem_rdata),
      .size       (size),
      .zero_ext   (acc_unsigned),
      .byte_lane  (byte_lane),
      .half_upper (half_upper),
      .fault      (fault),
      .value      (rd_value)
   );

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        acc_size,
   input logic              acc_unsigned,
   input logic [31:0]       wr_data,
   input logic [31:0]       mem_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_be,
   input logic [31:0]       mem_wdata,
   input logic [31:0]       rd_value,
   input logic              misalign
);

   always_comb begin
      if (!$isunknown({acc_addr, acc_size, acc_unsigned, wr_data, mem_rdata})) begin
         AST_WORD_ADDR: assert (mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == acc_addr[ADDR_W-1:2]); // R1
         AST_BYTE_ONE_LANE: assert (acc_size != 2'b00 || (!misalign && $countones(mem_be) == 1)); // R2
         AST_HALF_TWO_LANES: assert (acc_size != 2'b01 || misalign || mem_be == 4'b0011 || mem_be == 4'b1100); // R3
         AST_WORD_ALL_LANES: assert (acc_size != 2'b10 || misalign || (mem_be == 4'b1111 && mem_wdata == wr_data)); // R4
         AST_FAULT_NO_LANES: assert (!misalign || mem_be == 4'b0000); // R5
         AST_RSVD_FAULTS: assert (acc_size != 2'b11 || misalign); // R5
         AST_ZERO_EXT_BYTE: assert (!(acc_size == 2'b00 && acc_unsigned) || rd_value[31:8] == 24'h0); // R7
         AST_SIGN_EXT_BYTE: assert (!(acc_size == 2'b00 && !acc_unsigned) || rd_value[31:8] == {24{rd_value[7]}}); // R7
         AST_SIGN_EXT_HALF: assert (!(acc_size == 2'b01 && !acc_unsigned && !misalign) || rd_value[31:16] == {16{rd_value[15]}}); // R8
         AST_WORD_PASS: assert (!(acc_size == 2'b10 && !misalign) || rd_value == mem_rdata); // R9
         AST_FAULT_ZERO_LOAD: assert (!misalign || rd_value == 32'h0); // R10
         for (int i = 0; i < 4; i++) begin
            AST_BYTE_LANE_DATA: assert (!(acc_size == 2'b00 && mem_be[i]) || mem_wdata[8*i +: 8] == wr_data[7:0]); // R6
         end
      end
   end

endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .acc_addr     (acc_addr),
   .acc_size     (acc_size),
   .acc_unsigned (acc_unsigned),
   .wr_data      (wr_data),
   .mem_rdata    (mem_rdata),
   .mem_addr     (mem_addr),
   .mem_be       (mem_be),
   .mem_wdata    (mem_wdata),
   .rd_value     (rd_value),
   .misalign     (misalign)
);

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] acc_addr;
   logic [1:0]  acc_size;
   logic        acc_unsigned;
   logic [31:0] wr_data;
   logic [31:0] mem_rdata;

   logic [31:0] le_addr, le_wdata, le_rd;
   logic [3:0]  le_be;
   logic        le_mis;
   logic [15:0] be_addr;
   logic [31:0] be_wdata, be_rd;
   logic [3:0]  be_be;
   logic        be_mis;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   lsu_lane_unit #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) uut (
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_unsigned(acc_unsigned),
      .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_addr(le_addr),
      .mem_be(le_be), .mem_wdata(le_wdata), .rd_value(le_rd), .misalign(le_mis));

   lsu_lane_unit #(.ADDR_W(16), .BIG_ENDIAN(1'b1)) uut_be (
      .acc_addr(acc_addr[15:0]), .acc_size(acc_size), .acc_unsigned(acc_unsigned),
      .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_addr(be_addr),
      .mem_be(be_be), .mem_wdata(be_wdata), .rd_value(be_rd), .misalign(be_mis));

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Byte held at address a of a word, per byte order.
   function automatic logic [7:0] byte_at(input bit big, input logic [31:0] w, input int a);
      return big ? w[8*(3-a) +: 8] : w[8*a +: 8];
   endfunction

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction

   function automatic int span(input logic [1:0] sz);
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
   endfunction

   task automatic apply(input logic [31:0] a, input logic [1:0] sz, input logic uns,
                        input logic [31:0] wd, input logic [31:0] rd);
      @(negedge clk);
      acc_addr = a; acc_size = sz; acc_unsigned = uns; wr_data = wd; mem_rdata = rd;
      #1;
   endtask

   task automatic t_idle();
      apply(32'h0, 2'b00, 1'b0, 32'h0, 32'h0);
      check("R1", "idle addr le", le_addr, 32'h0);
      check("R2", "idle be le", {28'h0, le_be}, 32'h1);
      check("R2", "idle be be", {28'h0, be_be}, 32'h8);
      check("R5", "idle misalign", {30'h0, le_mis, be_mis}, 32'h0);
   endtask

   task automatic t_word_addr();
      apply(32'h1234_5677, 2'b00, 1'b0, 32'h0, 32'h0);
      check("R1", "addr le", le_addr, 32'h1234_5674);
      check("R1", "addr be16", {16'h0, be_addr}, 32'h0000_5674);
      apply(32'hFFFF_FFFE, 2'b01, 1'b0, 32'h0, 32'h0);
      check("R1", "addr top le", le_addr, 32'hFFFF_FFFC);
   endtask

   // Store of one size at one offset, checked for both byte orders.
   task automatic t_store(input logic [1:0] sz, input int off, input logic [31:0] d);
      logic [31:0] old_w, new_w, wdat, exp_be;
      logic [3:0]  be;
      logic [7:0]  exp_b;
      int          k;
      string       req;
      req = (sz == 2'b00) ? "R2" : (sz == 2'b01) ? "R3" : "R4";
      apply(32'h0000_0100 + off, sz, 1'b0, d, 32'h0);
      for (int u = 0; u < 2; u++) begin
         bit big = (u == 1);
         be   = big ? be_be : le_be;
         wdat = big ? be_wdata : le_wdata;
         exp_be = 0;
         for (int a = off; a < off + span(sz); a++) exp_be[big ? 3-a : a] = 1'b1;
         check(req, big ? "lanes be" : "lanes le", {28'h0, be}, exp_be);
         if (sz == 2'b00) check("R6", "byte replica", wdat, {4{d[7:0]}});
         if (sz == 2'b01) check("R6", "half replica", wdat, {2{d[15:0]}});
         if (sz == 2'b10) check("R4", "word data", wdat, d);
         old_w = 0;
         for (int a = 0; a < 4; a++) old_w[big ? 8*(3-a) : 8*a +: 8] = 8'h10 + 8'(a);
         new_w = (old_w & ~lane_mask(be)) | (wdat & lane_mask(be));
         for (int a = 0; a < 4; a++) begin
            k = a - off;
            if (k >= 0 && k < span(sz)) exp_b = big ? d[8*(span(sz)-1-k) +: 8] : d[8*k +: 8];
            else exp_b = 8'h10 + 8'(a);
            check("R6", big ? "mem byte be" : "mem byte le", {24'h0, byte_at(big, new_w, a)}, {24'h0, exp_b});
         end
      end
   endtask

   // Load of one size at one offset, expected from the per-address byte model.
   task automatic t_load(input logic [1:0] sz, input int off, input logic uns, input logic [31:0] w);
      logic [31:0] exp_v, act;
      logic [15:0] h;
      logic [7:0]  b;
      string       req;
      req = (sz == 2'b00) ? "R7" : (sz == 2'b01) ? "R8" : "R9";
      apply(32'h0000_0200 + off, sz, uns, 32'h0, w);
      for (int u = 0; u < 2; u++) begin
         bit big = (u == 1);
         act = big ? be_rd : le_rd;
         if (sz == 2'b00) begin
            b = byte_at(big, w, off);
            exp_v = uns ? {24'h0, b} : {{24{b[7]}}, b};
         end else if (sz == 2'b01) begin
            h = big ? {byte_at(big, w, off), byte_at(big, w, off+1)}
                    : {byte_at(big, w, off+1), byte_at(big, w, off)};
            exp_v = uns ? {16'h0, h} : {{16{h[15]}}, h};
         end else exp_v = w;
         check(req, big ? "load be" : "load le", act, exp_v);
      end
   endtask

   task automatic t_misalign(input logic [1:0] sz, input int off);
      apply(32'h0000_0300 + off, sz, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D);
      check("R5", "fault flags", {30'h0, le_mis, be_mis}, 32'h3);
      check("R5", "fault lanes", {24'h0, le_be, be_be}, 32'h0);
      check("R10", "fault load le", le_rd, 32'h0);
      check("R10", "fault load be", be_rd, 32'h0);
   endtask

   task automatic t_endian_example();
      logic [7:0] exp_big [4] = '{8'h87, 8'h65, 8'h43, 8'h21};
      logic [7:0] exp_lit [4] = '{8'h21, 8'h43, 8'h65, 8'h87};
      for (int a = 0; a < 4; a++) begin
         apply(32'h0 + a, 2'b00, 1'b1, 32'h0, 32'h8765_4321);
         check("R11", "byte load be", be_rd, {24'h0, exp_big[a]});
         check("R11", "byte load le", le_rd, {24'h0, exp_lit[a]});
      end
      apply(32'h0, 2'b10, 1'b0, 32'h8765_4321, 32'h0);
      for (int a = 0; a < 4; a++) begin
         check("R11", "word store be", {24'h0, byte_at(1'b1, be_wdata, a)}, {24'h0, exp_big[a]});
         check("R11", "word store le", {24'h0, byte_at(1'b0, le_wdata, a)}, {24'h0, exp_lit[a]});
      end
   endtask

   initial begin
      acc_addr = 0; acc_size = 0; acc_unsigned = 0; wr_data = 0; mem_rdata = 0;
      t_idle();
      t_word_addr();
      for (int o = 0; o < 4; o++) t_store(2'b00, o, 32'h1234_56A7 + 32'(o));
      t_store(2'b01, 0, 32'h0000_BEEF);
      t_store(2'b01, 2, 32'hFFFF_1C2D);
      t_store(2'b10, 0, 32'hA1B2_C3D4);
      foreach (t_words[i]) begin
         for (int o = 0; o < 4; o++) begin
            t_load(2'b00, o, 1'b0, t_words[i]);
            t_load(2'b00, o, 1'b1, t_words[i]);
         end
         for (int o = 0; o < 4; o += 2) begin
            t_load(2'b01, o, 1'b0, t_words[i]);
            t_load(2'b01, o, 1'b1, t_words[i]);
         end
         t_load(2'b10, 0, 1'b0, t_words[i]);
         t_load(2'b10, 0, 1'b1, t_words[i]);
      end
      t_misalign(2'b01, 1);
      t_misalign(2'b01, 3);
      t_misalign(2'b10, 1);
      t_misalign(2'b10, 2);
      t_misalign(2'b10, 3);
      t_misalign(2'b11, 0);
      t_endian_example();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   logic [31:0] t_words [3] = '{32'hFE80_7F01, 32'h8765_4321, 32'h00FF_FF00};

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule